// File: doc/BRIEF.md
# Page Migration Utility Estimator

This block sits beside the controller of a slow memory tier and keeps a small direct-indexed table of access statistics, one entry per tracked page. Each access reports the page, whether it is a read or a write, whether it missed the open row, and how many requests the owning application has in flight at that moment. Row misses are counted separately for reads and writes. The in-flight figure is folded into a per-page running sum and sample count for each access type, so that an average concurrency over the current interval is available.

On a query the block forms, for the chosen page, the latency that moving it to the fast tier would save: miss count times the latency gap, for reads and for writes. Each saving is divided by the page's average concurrency for that type. The write part is weighted by the chance that the application stalls while its write queue drains. The sum is weighted by the application's sensitivity and then compared with a threshold to decide migrate or keep. Latencies, the stall chance and the sensitivity are unsigned fixed-point values with 8 fractional bits. The divisions run on one shared bit-serial divider, so a query takes a fixed number of cycles and reports completion with a one-cycle pulse.

Top module: `page_util_est`

## Requirements
- R1: After reset every page entry is empty, busy, done and migrate are 0 and utility is 0; a query of any page then returns utility 0 and migrate 0.
- R2: An access with acc_miss = 0 (row hit) leaves both miss counts of its page unchanged; only row misses raise the estimate.
- R3: Read misses (acc_write = 0) and write misses (acc_write = 1) use separate counters; the read saving is read misses times (lat_slow_rd minus lat_fast_rd), the write saving is write misses times (lat_slow_wr minus lat_fast_wr).
- R4: When a fast latency is not below the matching slow latency, that latency gap is taken as 0.
- R5: Every access adds max(acc_outstanding, 1) to its type's concurrency sum and 1 to its sample count; each saving is divided by sum/count using floor(saving × count / sum), and with no samples the divisor is 1.
- R6: The write term is floor(write stall term × stall_prob / 256), stall_prob holding 8 fractional bits.
- R7: utility = floor((read term + write term) × query_sens / 256); migrate is 1 only when utility is strictly greater than threshold; sens and threshold are taken when the query is accepted.
- R8: interval_end clears all concurrency sums and counts but no miss counts; an access in the same cycle becomes the first sample of the new interval.
- R9: Miss counters stop at 255, and concurrency sample counts stop at 255 (sum and count then freeze together).
- R10: A query is accepted when query_valid is high and busy is low; busy is high from the next cycle until done, done is a one-cycle pulse that coincides with busy falling, and a query raised while busy is ignored.
- R11: A query accepted in the same cycle as an access to the same page uses the page statistics from before that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access report valid |
| acc_page | input | PAGE_W | Page index of the access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_miss | input | 1 | 1 when the access missed the open row |
| acc_outstanding | input | CONC_W | Requests of the owning application in flight |
| interval_end | input | 1 | Interval boundary, clears concurrency averages |
| lat_slow_rd | input | LAT_W | Slow-tier read miss latency, 8 fractional bits |
| lat_fast_rd | input | LAT_W | Fast-tier read miss latency, 8 fractional bits |
| lat_slow_wr | input | LAT_W | Slow-tier write miss latency, 8 fractional bits |
| lat_fast_wr | input | LAT_W | Fast-tier write miss latency, 8 fractional bits |
| stall_prob | input | LAT_W | Write-drain stall probability, 8 fractional bits |
| query_valid | input | 1 | Start a utility evaluation |
| query_page | input | PAGE_W | Page to evaluate |
| query_sens | input | LAT_W | Owning application's sensitivity, 8 fractional bits |
| threshold | input | UTIL_W | Migration threshold |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| utility | output | UTIL_W | Computed utility, held until the next result |
| migrate | output | 1 | Utility above threshold, held until the next result |

## Verification
An access and a query can land on the same page in the same cycle, and so can an access and an interval boundary. The bench drives both collisions on purpose: a query paired with a read miss on its own page must return the value computed from the statistics as they stood before the miss, and an interval boundary paired with an access must leave that access as the only concurrency sample. Both are judged against a bench-side model of the page table whose results are queued when the query is raised and compared when done pulses.

// File: rtl/page_util_est.sv
module page_util_est #(
  parameter int PAGE_W = 4,
  parameter int CNT_W  = 8,
  parameter int CONC_W = 6,
  parameter int NS_W   = 8,
  parameter int SUM_W  = 14,
  parameter int LAT_W  = 16,
  parameter int FRAC   = 8,
  localparam int SAVE_W  = CNT_W + LAT_W,
  localparam int NUM_W   = SAVE_W + NS_W,
  localparam int STALL_W = SAVE_W + LAT_W - FRAC + 1,
  localparam int UTIL_W  = STALL_W + LAT_W - FRAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [PAGE_W-1:0] acc_page,
  input  logic              acc_write,
  input  logic              acc_miss,
  input  logic [CONC_W-1:0] acc_outstanding,
  input  logic              interval_end,
  input  logic [LAT_W-1:0]  lat_slow_rd,
  input  logic [LAT_W-1:0]  lat_fast_rd,
  input  logic [LAT_W-1:0]  lat_slow_wr,
  input  logic [LAT_W-1:0]  lat_fast_wr,
  input  logic [LAT_W-1:0]  stall_prob,
  input  logic              query_valid,
  input  logic [PAGE_W-1:0] query_page,
  input  logic [LAT_W-1:0]  query_sens,
  input  logic [UTIL_W-1:0] threshold,
  output logic              busy,
  output logic              done,
  output logic [UTIL_W-1:0] utility,
  output logic              migrate
);
  localparam int PAGES = 1 << PAGE_W;
  localparam int CW    = $clog2(NUM_W);

  typedef enum logic [1:0] {S_IDLE, S_DRD, S_DWR, S_FIN} state_t;

  logic [CNT_W-1:0] mrd [PAGES];
  logic [CNT_W-1:0] mwr [PAGES];
  logic [SUM_W-1:0] srd [PAGES];
  logic [SUM_W-1:0] swr [PAGES];
  logic [NS_W-1:0]  nrd [PAGES];
  logic [NS_W-1:0]  nwr [PAGES];

  // access update path
  logic [CONC_W-1:0] conc;
  logic [SUM_W-1:0]  s_base, s_new;
  logic [NS_W-1:0]   n_base, n_new;
  logic [SUM_W:0]    s_add;
  logic              take;
  logic [CNT_W-1:0]  m_base, m_new;

  assign conc   = (acc_outstanding == '0) ? CONC_W'(1) : acc_outstanding;
  assign s_base = interval_end ? '0 : (acc_write ? swr[acc_page] : srd[acc_page]);
  assign n_base = interval_end ? '0 : (acc_write ? nwr[acc_page] : nrd[acc_page]);
  assign s_add  = {1'b0, s_base} + (SUM_W+1)'(conc);
  assign take   = (n_base != '1) && !s_add[SUM_W];
  assign s_new  = take ? s_add[SUM_W-1:0] : s_base;
  assign n_new  = take ? n_base + NS_W'(1) : n_base;
  assign m_base = acc_write ? mwr[acc_page] : mrd[acc_page];
  assign m_new  = (m_base == '1) ? m_base : m_base + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGES; i++) begin
        mrd[i] <= '0; mwr[i] <= '0;
        srd[i] <= '0; swr[i] <= '0;
        nrd[i] <= '0; nwr[i] <= '0;
      end
    end else begin
      if (interval_end)
        for (int i = 0; i < PAGES; i++) begin
          srd[i] <= '0; swr[i] <= '0;
          nrd[i] <= '0; nwr[i] <= '0;
        end
      if (acc_valid) begin
        if (acc_write) begin
          swr[acc_page] <= s_new;
          nwr[acc_page] <= n_new;
          if (acc_miss) mwr[acc_page] <= m_new;
        end else begin
          srd[acc_page] <= s_new;
          nrd[acc_page] <= n_new;
          if (acc_miss) mrd[acc_page] <= m_new;
        end
      end
    end
  end

  // query operand formation
  logic [LAT_W-1:0]  gap_rd, gap_wr;
  logic [SAVE_W-1:0] save_rd, save_wr;
  logic [NUM_W-1:0]  num_rd, num_wr;
  logic [SUM_W-1:0]  den_rd, den_wr;

  assign gap_rd  = (lat_slow_rd > lat_fast_rd) ? lat_slow_rd - lat_fast_rd : '0;
  assign gap_wr  = (lat_slow_wr > lat_fast_wr) ? lat_slow_wr - lat_fast_wr : '0;
  assign save_rd = SAVE_W'(mrd[query_page]) * SAVE_W'(gap_rd);
  assign save_wr = SAVE_W'(mwr[query_page]) * SAVE_W'(gap_wr);
  assign num_rd  = (nrd[query_page] == '0) ? NUM_W'(save_rd)
                                           : NUM_W'(save_rd) * NUM_W'(nrd[query_page]);
  assign num_wr  = (nwr[query_page] == '0) ? NUM_W'(save_wr)
                                           : NUM_W'(save_wr) * NUM_W'(nwr[query_page]);
  assign den_rd  = (nrd[query_page] == '0) ? SUM_W'(1) : srd[query_page];
  assign den_wr  = (nwr[query_page] == '0) ? SUM_W'(1) : swr[query_page];

  // bit-serial restoring divider
  state_t            st;
  logic [CW-1:0]     step;
  logic [NUM_W-1:0]  dnum, dquo, qfin;
  logic [SUM_W:0]    drem, trial, rem_n;
  logic [SUM_W-1:0]  dden;
  logic              ge;
  logic [NUM_W-1:0]  wnum_q;
  logic [SUM_W-1:0]  wden_q;
  logic [SAVE_W-1:0] q_rd, q_wr;
  logic [LAT_W-1:0]  p_q, sens_q;
  logic [UTIL_W-1:0] thr_q;

  assign trial = {drem[SUM_W-1:0], dnum[NUM_W-1]};
  assign ge    = trial >= {1'b0, dden};
  assign rem_n = ge ? trial - {1'b0, dden} : trial;
  assign qfin  = {dquo[NUM_W-2:0], ge};

  // final weighting
  logic [SAVE_W+LAT_W-1:0]   pw_full;
  logic [STALL_W-1:0]        stall;
  logic [STALL_W+LAT_W-1:0]  u_full;
  logic [UTIL_W-1:0]         util_n;

  assign pw_full = (SAVE_W+LAT_W)'(q_wr) * (SAVE_W+LAT_W)'(p_q);
  assign stall   = STALL_W'(q_rd) + STALL_W'(pw_full >> FRAC);
  assign u_full  = (STALL_W+LAT_W)'(stall) * (STALL_W+LAT_W)'(sens_q);
  assign util_n  = UTIL_W'(u_full >> FRAC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= '0;
      dnum <= '0; dquo <= '0; drem <= '0; dden <= '0;
      wnum_q <= '0; wden_q <= '0; q_rd <= '0; q_wr <= '0;
      p_q <= '0; sens_q <= '0; thr_q <= '0;
      busy <= 1'b0; done <= 1'b0; utility <= '0; migrate <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (query_valid) begin
          dnum <= num_rd; dden <= den_rd; drem <= '0; dquo <= '0; step <= '0;
          wnum_q <= num_wr; wden_q <= den_wr;
          p_q <= stall_prob; sens_q <= query_sens; thr_q <= threshold;
          busy <= 1'b1; st <= S_DRD;
        end
        S_DRD, S_DWR: begin
          drem <= rem_n; dnum <= dnum << 1; dquo <= qfin; step <= step + CW'(1);
          if (step == CW'(NUM_W-1)) begin
            step <= '0;
            if (st == S_DRD) begin
              q_rd <= SAVE_W'(qfin);
              dnum <= wnum_q; dden <= wden_q; drem <= '0; dquo <= '0;
              st <= S_DWR;
            end else begin
              q_wr <= SAVE_W'(qfin);
              st <= S_FIN;
            end
          end
        end
        default: begin
          utility <= util_n;
          migrate <= util_n > thr_q;
          done <= 1'b1; busy <= 1'b0; st <= S_IDLE;
        end
      endcase
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r10_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(utility) && $stable(migrate)));
  a_r9_read_miss_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_miss && !acc_write) |=> mrd[$past(acc_page)] >= $past(mrd[acc_page]));
  a_r8_interval_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_end && !acc_valid) |=> (nrd[$past(acc_page)] == '0 && nwr[$past(acc_page)] == '0));
endmodule

// File: tb/page_util_est_test.sv
module page_util_est_test;
  localparam int UW = 41;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, acc_miss = 0, interval_end = 0, query_valid = 0;
  logic [3:0] acc_page = 0, query_page = 0;
  logic [5:0] acc_outstanding = 0;
  logic [15:0] lat_slow_rd, lat_fast_rd, lat_slow_wr, lat_fast_wr, stall_prob, query_sens;
  logic [UW-1:0] threshold;
  logic busy, done, migrate;
  logic [UW-1:0] utility;

  page_util_est uut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  int mr[16], mw[16], sr[16], sw[16], nr[16], nw[16];
  longint qu[$];
  bit qm[$];
  string qt[$];

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic void model_acc(int pg, bit wr, bit miss, int out, bit clr);
    int c, s, n;
    if (clr) for (int i = 0; i < 16; i++) begin sr[i] = 0; sw[i] = 0; nr[i] = 0; nw[i] = 0; end
    c = (out == 0) ? 1 : out;
    s = wr ? sw[pg] : sr[pg];
    n = wr ? nw[pg] : nr[pg];
    if (n != 255 && s + c <= 16383) begin s += c; n++; end
    if (wr) begin sw[pg] = s; nw[pg] = n; if (miss && mw[pg] < 255) mw[pg]++; end
    else    begin sr[pg] = s; nr[pg] = n; if (miss && mr[pg] < 255) mr[pg]++; end
  endfunction

  function automatic longint term(int cnt, int slow, int fast, int n, int s);
    longint gap, save;
    gap = (slow > fast) ? slow - fast : 0;
    save = longint'(cnt) * gap;
    return (n == 0) ? save : (save * n) / s;
  endfunction

  function automatic longint exp_util(int pg, int sens);
    longint a, b;
    a = term(mr[pg], lat_slow_rd, lat_fast_rd, nr[pg], sr[pg]);
    b = term(mw[pg], lat_slow_wr, lat_fast_wr, nw[pg], sw[pg]);
    b = (b * stall_prob) >> 8;
    return ((a + b) * sens) >> 8;
  endfunction

  task automatic acc(int pg, bit wr, bit miss, int out, bit clr);
    @(negedge clk);
    acc_valid = 1; acc_page = pg[3:0]; acc_write = wr; acc_miss = miss;
    acc_outstanding = out[5:0]; interval_end = clr;
    model_acc(pg, wr, miss, out, clr);
    @(negedge clk);
    acc_valid = 0; interval_end = 0;
  endtask

  task automatic tick_end();
    @(negedge clk);
    interval_end = 1;
    for (int i = 0; i < 16; i++) begin sr[i] = 0; sw[i] = 0; nr[i] = 0; nw[i] = 0; end
    @(negedge clk);
    interval_end = 0;
  endtask

  task automatic query(int pg, int sens, longint thr, string tag);
    longint u;
    @(negedge clk);
    u = exp_util(pg, sens);
    query_valid = 1; query_page = pg[3:0]; query_sens = sens[15:0]; threshold = thr[UW-1:0];
    qu.push_back(u); qm.push_back(u > thr); qt.push_back(tag);
    @(negedge clk);
    query_valid = 0;
    wait (qu.size() == 0);
    @(negedge clk);
  endtask

  // monitor: compare each result against the queued expectation
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (qu.size() == 0) check(0, "R10 unexpected done", 1, 0);
      else begin
        longint eu; bit em; string t;
        eu = qu.pop_front(); em = qm.pop_front(); t = qt.pop_front();
        check(longint'(utility) == eu, {t, " utility"}, longint'(utility), eu);
        check(migrate == em, {t, " migrate"}, migrate, em);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  initial begin
    longint u0;
    lat_slow_rd = 16'h0400; lat_fast_rd = 16'h0100;
    lat_slow_wr = 16'h0800; lat_fast_wr = 16'h0100;
    stall_prob = 16'h0080; query_sens = 16'h0100; threshold = 0;
    for (int i = 0; i < 16; i++) begin mr[i] = 0; mw[i] = 0; sr[i] = 0; sw[i] = 0; nr[i] = 0; nw[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(done == 0, "R1 done", done, 0);
    check(migrate == 0, "R1 migrate", migrate, 0);
    check(utility == 0, "R1 utility", utility, 0);
    query(3, 256, 0, "R1 empty page");

    // R2 row hits leave the estimate at zero
    for (int k = 0; k < 5; k++) acc(1, 0, 0, 2, 0);
    acc(1, 1, 0, 2, 0);
    query(1, 256, 0, "R2 hits only");

    // R3 / R5 separate read and write terms with averaged concurrency
    for (int k = 0; k < 3; k++) acc(2, 0, 1, 4, 0);
    acc(2, 0, 0, 9, 0);
    for (int k = 0; k < 2; k++) acc(2, 1, 1, 2, 0);
    query(2, 256, 0, "R3 mixed misses");
    // R5 zero outstanding taken as one
    acc(4, 0, 1, 0, 0); acc(4, 0, 1, 0, 0);
    query(4, 256, 0, "R5 zero concurrency");

    // R4 inverted read gap
    lat_fast_rd = 16'h0500;
    query(2, 256, 0, "R4 gap clamp");
    lat_fast_rd = 16'h0100;

    // R6 stall probability weighting
    stall_prob = 16'h0000; query(2, 256, 0, "R6 p zero");
    stall_prob = 16'h0100; query(2, 256, 0, "R6 p one");
    stall_prob = 16'h0080;

    // R7 sensitivity and strict threshold
    u0 = exp_util(2, 512);
    query(2, 512, u0, "R7 equal threshold");
    query(2, 512, u0 - 1, "R7 below threshold");

    // R8 interval boundary clears averages only
    tick_end();
    query(2, 256, 0, "R8 after clear");
    acc(2, 0, 1, 8, 1);
    query(2, 256, 0, "R8 clear with access");

    // R9 saturation of miss counts and sample counts
    for (int k = 0; k < 260; k++) acc(5, 1, 1, 3, 0);
    query(5, 256, 0, "R9 saturated");

    // R11 query and access to the same page in one cycle
    acc(6, 0, 1, 2, 0);
    @(negedge clk);
    u0 = exp_util(6, 256);
    qu.push_back(u0); qm.push_back(u0 > 0); qt.push_back("R11 same cycle");
    query_valid = 1; query_page = 6; query_sens = 16'h0100; threshold = 0;
    acc_valid = 1; acc_page = 6; acc_write = 0; acc_miss = 1; acc_outstanding = 1;
    model_acc(6, 0, 1, 1, 0);
    @(negedge clk);
    query_valid = 0; acc_valid = 0;
    wait (qu.size() == 0);
    @(negedge clk);

    // R10 busy handshake, second request ignored
    @(negedge clk);
    u0 = exp_util(2, 256);
    qu.push_back(u0); qm.push_back(u0 > 0); qt.push_back("R10 single result");
    query_valid = 1; query_page = 2; query_sens = 16'h0100; threshold = 0;
    @(negedge clk);
    check(busy == 1, "R10 busy after accept", busy, 1);
    query_page = 5;
    @(negedge clk);
    query_valid = 0;
    wait (qu.size() == 0);
    repeat (100) @(negedge clk);
    check(busy == 0, "R10 idle after ignored request", busy, 0);
    summary();
  end
endmodule